// File: doc/BRIEF.md
# Recursive QPP Interleaver Address Generator

This block produces the quadratic permutation address sequence addr(i) = (f1*i + f2*i*i) mod K for a single code block. It emits one address per enabled cycle and uses only adders, comparators and multiplexers. A neighbouring parameter table supplies the block length K and the two coefficients f1 and f2. A start strobe captures them, and the block then walks the index i from 0 to K-1 under a step enable. The addresses drive the interleaved read and write ports of the input and extrinsic buffers.

The block has no multiplier. It keeps two running terms: the current address, and an auxiliary term lam(i) = (2*f2*i) mod K. Each step applies addr(i+1) = (addr(i) + c1 + lam(i)) mod K, where c1 = (f1+f2) mod K. It also applies lam(i+1) = (lam(i) + c2) mod K, where c2 = (2*f2) mod K. Both constants are reduced once, when start is seen. The three-operand sum is brought back into range by two cascaded conditional subtractions of K. The longest path is therefore a few adders and multiplexers deep.

Top module: `qpp_addr_gen`

## Requirements
- R1: After reset, valid and last are both low.
- R2: One cycle after start is seen high, valid is high, the address is 0 and the index is 0, whatever the previous state.
- R3: Each step accepted while valid is high and last is low advances the index by one and updates the address to (f1*i + f2*i*i) mod K for the new index i, visible on the next cycle.
- R4: While valid is high and neither step nor start is high, the address, the index and valid hold their values.
- R5: Last is high exactly when valid is high and the index equals K-1.
- R6: A step accepted while last is high takes valid and last low on the next cycle.
- R7: Step while valid is low has no effect: valid stays low and no sequence begins.
- R8: Start while a sequence is running abandons it and begins a new sequence with the newly supplied K, f1 and f2.
- R9: Over a full sequence every address is below K, and the K addresses form a permutation of 0..K-1. The inputs must satisfy 2 <= K <= 2^W-1 and f1, f2 < K.
- R10: K, f1 and f2 are sampled only in the start cycle. Changing them later does not alter the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| startIn | input | 1 | Capture K, f1, f2 and restart the sequence at index 0 |
| kIn | input | W (13) | Block length K |
| f1In | input | W (13) | Linear coefficient f1, below K |
| f2In | input | W (13) | Quadratic coefficient f2, below K |
| stepIn | input | 1 | Advance to the next index |
| addrOut | output | W (13) | Interleaved address for the current index |
| idxOut | output | W (13) | Current index i |
| validOut | output | 1 | A sequence is active and addrOut is meaningful |
| lastOut | output | 1 | Current index is K-1 |

## Verification
Each address depends on every earlier update of both running terms. A wrong precomputed constant, a missed reduction or a stale auxiliary term therefore produces a wrong address within one or two steps, and that error stays in the sequence. Comparing every emitted address against a direct evaluation of the quadratic catches such faults at the first bad index. The permutation check over the whole block exposes duplicate or out-of-range addresses. A slip in the control shows at once as a missing or late last flag, or as a valid flag that fails to drop.

// File: rtl/qpp_pkg.sv
package qpp_pkg;
  parameter int DEF_ADDR_W = 13;

  typedef struct packed {
    logic load;
    logic advance;
  } qpp_strobe_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } qpp_state_t;
endpackage

// File: rtl/qpp_mod_add.sv
module qpp_mod_add #(
  parameter int W = 13
) (
  input  logic [W-1:0] aIn,
  input  logic [W-1:0] bIn,
  input  logic [W-1:0] modIn,
  output logic [W-1:0] sumOut
);
  // Both operands are below modIn, so one conditional subtraction suffices.
  logic [W:0] rawSum;
  logic [W:0] modWide;
  logic [W:0] reduced;

  assign rawSum  = {1'b0, aIn} + {1'b0, bIn};
  assign modWide = {1'b0, modIn};
  assign reduced = rawSum - modWide;
  assign sumOut  = (rawSum >= modWide) ? reduced[W-1:0] : rawSum[W-1:0];
endmodule

// File: rtl/qpp_ctrl.sv
module qpp_ctrl
  import qpp_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startIn,
  input  logic        stepIn,
  input  logic        atLast,
  output qpp_strobe_t strobes,
  output logic        validOut,
  output logic        lastOut
);
  qpp_state_t stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    strobes.load    = startIn;
    strobes.advance = 1'b0;
    if (startIn) begin
      stateD = ST_RUN;
    end else if (stateQ == ST_RUN && stepIn) begin
      if (atLast) stateD = ST_IDLE;
      else        strobes.advance = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  assign validOut = (stateQ == ST_RUN);
  assign lastOut  = validOut && atLast;
endmodule

// File: rtl/qpp_datapath.sv
module qpp_datapath
  import qpp_pkg::*;
#(
  parameter int W = DEF_ADDR_W
) (
  input  logic        clk,
  input  logic        rstN,
  input  qpp_strobe_t strobes,
  input  logic [W-1:0] kIn,
  input  logic [W-1:0] f1In,
  input  logic [W-1:0] f2In,
  output logic [W-1:0] addrOut,
  output logic [W-1:0] idxOut,
  output logic        atLast
);
  localparam int RED_STAGES = 2;
  localparam int SW = W + 2;

  logic [W-1:0] kQ, kLastQ, incQ, dblQ;
  logic [W-1:0] addrQ, idxQ, lamQ;
  logic [W-1:0] incNew, dblNew, lamNext, addrNext;

  // Constants reduced once at start
  qpp_mod_add #(.W(W)) uIncRed (.aIn(f1In), .bIn(f2In), .modIn(kIn), .sumOut(incNew));
  qpp_mod_add #(.W(W)) uDblRed (.aIn(f2In), .bIn(f2In), .modIn(kIn), .sumOut(dblNew));

  // Auxiliary term update
  qpp_mod_add #(.W(W)) uLamRed (.aIn(lamQ), .bIn(dblQ), .modIn(kQ), .sumOut(lamNext));

  // Three-operand sum, reduced by cascaded conditional subtraction
  logic [SW-1:0] kWide;
  logic [SW-1:0] redStage [RED_STAGES+1];

  assign kWide       = {2'b00, kQ};
  assign redStage[0] = {2'b00, addrQ} + {2'b00, incQ} + {2'b00, lamQ};

  for (genvar g = 0; g < RED_STAGES; g++) begin : gRed
    logic [SW-1:0] diff;
    assign diff          = redStage[g] - kWide;
    assign redStage[g+1] = (redStage[g] >= kWide) ? diff : redStage[g];
  end

  assign addrNext = redStage[RED_STAGES][W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      kQ     <= '0;
      kLastQ <= '0;
      incQ   <= '0;
      dblQ   <= '0;
      addrQ  <= '0;
      idxQ   <= '0;
      lamQ   <= '0;
    end else if (strobes.load) begin
      kQ     <= kIn;
      kLastQ <= kIn - W'(1);
      incQ   <= incNew;
      dblQ   <= dblNew;
      addrQ  <= '0;
      idxQ   <= '0;
      lamQ   <= '0;
    end else if (strobes.advance) begin
      addrQ <= addrNext;
      lamQ  <= lamNext;
      idxQ  <= idxQ + W'(1);
    end
  end

  assign addrOut = addrQ;
  assign idxOut  = idxQ;
  assign atLast  = (idxQ == kLastQ);
endmodule

// File: rtl/qpp_addr_gen.sv
module qpp_addr_gen
  import qpp_pkg::*;
#(
  parameter int ADDR_W = DEF_ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startIn,
  input  logic [ADDR_W-1:0] kIn,
  input  logic [ADDR_W-1:0] f1In,
  input  logic [ADDR_W-1:0] f2In,
  input  logic              stepIn,
  output logic [ADDR_W-1:0] addrOut,
  output logic [ADDR_W-1:0] idxOut,
  output logic              validOut,
  output logic              lastOut
);
  qpp_strobe_t strobes;
  logic        atLast;

  qpp_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .startIn(startIn), .stepIn(stepIn),
    .atLast(atLast), .strobes(strobes), .validOut(validOut), .lastOut(lastOut)
  );

  qpp_datapath #(.W(ADDR_W)) uPath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .kIn(kIn), .f1In(f1In),
    .f2In(f2In), .addrOut(addrOut), .idxOut(idxOut), .atLast(atLast)
  );
endmodule

// File: rtl/qpp_addr_gen_chk.sv
module qpp_addr_gen_chk #(
  parameter int W = 13
) (
  input logic         clk,
  input logic         rstN,
  input logic         startIn,
  input logic         stepIn,
  input logic [W-1:0] kIn,
  input logic [W-1:0] addrOut,
  input logic [W-1:0] idxOut,
  input logic         validOut,
  input logic         lastOut
);
  logic [W-1:0] kSeen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        kSeen <= '0;
    else if (startIn) kSeen <= kIn;
  end

  assert_start_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    startIn |=> (validOut && addrOut == '0 && idxOut == '0));

  assert_idx_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    (validOut && stepIn && !lastOut && !startIn) |=> (validOut && idxOut == $past(idxOut) + W'(1)));

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (validOut && !stepIn && !startIn) |=> (validOut && $stable(addrOut) && $stable(idxOut)));

  assert_last_R5: assert property (@(posedge clk) disable iff (!rstN)
    lastOut |-> (validOut && idxOut == kSeen - W'(1)));

  assert_end_R6: assert property (@(posedge clk) disable iff (!rstN)
    (lastOut && stepIn && !startIn) |=> (!validOut && !lastOut));

  assert_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!validOut && !startIn) |=> !validOut);

  assert_range_R9: assert property (@(posedge clk) disable iff (!rstN)
    validOut |-> (addrOut < kSeen));
endmodule

bind qpp_addr_gen qpp_addr_gen_chk #(.W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .startIn(startIn), .stepIn(stepIn), .kIn(kIn),
  .addrOut(addrOut), .idxOut(idxOut), .validOut(validOut), .lastOut(lastOut)
);

// File: tb/qpp_addr_gen_test.sv
module qpp_addr_gen_test;
  localparam int W = 13;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startIn = 1'b0;
  logic stepIn = 1'b0;
  logic [W-1:0] kIn = '0, f1In = '0, f2In = '0;
  logic [W-1:0] addrOut, idxOut;
  logic validOut, lastOut;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;
  bit seen [8192];

  always #10 clk = ~clk;

  qpp_addr_gen #(.ADDR_W(W)) uut (
    .clk(clk), .rstN(rstN), .startIn(startIn), .kIn(kIn), .f1In(f1In),
    .f2In(f2In), .stepIn(stepIn), .addrOut(addrOut), .idxOut(idxOut),
    .validOut(validOut), .lastOut(lastOut)
  );

  function automatic int refAddr(int k, int f1, int f2, int i);
    longint t;
    t = (longint'(f1) * i + longint'(f2) * i * i) % k;
    return int'(t);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic doStart(int k, int f1, int f2);
    kIn = W'(k); f1In = W'(f1); f2In = W'(f2);
    startIn = 1'b1;
    @(negedge clk);
    startIn = 1'b0;
    check(validOut == 1'b1, "R2 valid", int'(validOut), 1);
    check(addrOut == '0, "R2 addr", int'(addrOut), 0);
    check(idxOut == '0, "R2 idx", int'(idxOut), 0);
  endtask

  // Full block, optional stalls and input scrambling after start (R10)
  task automatic runBlock(int k, int f1, int f2, int stallEvery, bit scramble);
    int distinct = 0;
    int bad = 0;
    for (int a = 0; a < 8192; a++) seen[a] = 1'b0;
    doStart(k, f1, f2);
    if (scramble) begin
      kIn = W'(k / 2 + 3); f1In = W'(1); f2In = W'(2);
    end
    for (int i = 0; i < k; i++) begin
      int exp = refAddr(k, f1, f2, i);
      if (int'(addrOut) != exp || int'(idxOut) != i) begin
        check(1'b0, scramble ? "R10 addr" : "R3 addr", int'(addrOut), exp);
        bad++;
      end
      if (lastOut != (i == k - 1)) begin
        check(1'b0, "R5 last", int'(lastOut), int'(i == k - 1));
        bad++;
      end
      if (addrOut >= W'(k) || seen[addrOut]) bad++;
      else begin seen[addrOut] = 1'b1; distinct++; end
      if (stallEvery > 0 && (i % stallEvery) == 1) begin
        stepIn = 1'b0;
        @(negedge clk);
        if (int'(addrOut) != exp || int'(idxOut) != i || !validOut) begin
          check(1'b0, "R4 hold", int'(addrOut), exp);
          bad++;
        end
      end
      stepIn = 1'b1;
      @(negedge clk);
    end
    stepIn = 1'b0;
    check(bad == 0, scramble ? "R10 sequence" : "R3 sequence", bad, 0);
    check(distinct == k, "R9 permutation", distinct, k);
    check(validOut == 1'b0, "R6 valid drop", int'(validOut), 0);
    check(lastOut == 1'b0, "R6 last drop", int'(lastOut), 0);
  endtask

  task automatic testReset();
    check(validOut == 1'b0, "R1 valid", int'(validOut), 0);
    check(lastOut == 1'b0, "R1 last", int'(lastOut), 0);
  endtask

  task automatic testIdleStep();
    stepIn = 1'b1;
    repeat (3) @(negedge clk);
    stepIn = 1'b0;
    check(validOut == 1'b0, "R7 valid", int'(validOut), 0);
    check(lastOut == 1'b0, "R7 last", int'(lastOut), 0);
  endtask

  task automatic testRestart();
    doStart(48, 7, 12);
    stepIn = 1'b1;
    repeat (5) @(negedge clk);
    check(int'(addrOut) == refAddr(48, 7, 12, 5), "R3 mid", int'(addrOut), refAddr(48, 7, 12, 5));
    stepIn = 1'b0;
    check(idxOut == W'(5), "R8 pre idx", int'(idxOut), 5);
    runBlock(40, 3, 10, 0, 1'b0);
  endtask

  task automatic testLastStall();
    doStart(40, 3, 10);
    stepIn = 1'b1;
    repeat (39) @(negedge clk);
    stepIn = 1'b0;
    @(negedge clk);
    check(lastOut == 1'b1, "R5 last held", int'(lastOut), 1);
    check(validOut == 1'b1, "R4 valid held at last", int'(validOut), 1);
    stepIn = 1'b1;
    @(negedge clk);
    stepIn = 1'b0;
    check(validOut == 1'b0, "R6 end", int'(validOut), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testIdleStep();
    runBlock(40, 3, 10, 0, 1'b0);
    runBlock(104, 7, 26, 3, 1'b0);
    runBlock(512, 31, 64, 0, 1'b1);
    testRestart();
    testLastStall();
    runBlock(6144, 263, 480, 7, 1'b0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule